// File: doc/BRIEF.md
# Operand Address Sequencer for an 8-bit Processor Core

This unit resolves the effective address of one instruction and fetches its operand over a single-issue, byte-wide memory read port. The core pulses `start` with a group select, a 3-bit mode field, a branch select and snapshots of the program counter and the A, X and Y registers. The sequencer then issues one read at a time. It fetches operand bytes at the program counter, chases zero-page pointers for the two indirect forms, adds the index registers, and finally reads the operand at the effective address.

When the sequence ends, `done` is high for one cycle. In that cycle the effective address, operand byte, advanced program counter, resolved mode code and illegal flag are presented together. Execution of the instruction, writes, stack work and cycle-exact timing belong to other blocks.

Top module: `eaddr_seq`

## Requirements
- R1: With `rel_sel`=0 and `grp_two`=0, field 000 gives mode 7 (indexed-indirect by X), 001 mode 2 (zero page), 010 mode 1 (immediate), 011 mode 4 (absolute), 100 mode 8 (indirect then indexed by Y), 101 mode 3 (zero page plus X), 110 mode 6 (absolute plus Y) and 111 mode 5 (absolute plus X), reported on `mode_out`.
- R2: With `rel_sel`=0 and `grp_two`=1, field 000 gives mode 1, 001 mode 2, 010 mode 0 (accumulator), 011 mode 4, 101 mode 3 and 111 mode 5. Fields 100 and 110 give mode 15 with `illegal`=1, no memory read, `operand`=0, `ea_out`=0 and `pc_out` equal to the PC given at start.
- R3: `rel_sel`=1 overrides the group and field and gives mode 9. One offset byte is read at PC, `pc_out`=PC+1, `operand` is the offset, and `ea_out` is PC+1 plus the offset taken as a signed byte, modulo 2^16.
- R4: Accumulator mode makes no memory read: `operand` is A, `ea_out`=0, `pc_out`=PC.
- R5: Immediate mode reads one byte at PC: `operand` is that byte, `ea_out`=PC, `pc_out`=PC+1.
- R6: Zero-page modes read the address byte B at PC and then the operand at `ea_out` = B (mode 2) or (B+X) mod 256 (mode 3). `pc_out`=PC+1 and two reads are made.
- R7: Absolute modes read the low byte at PC and the high byte at PC+1. X (mode 5), Y (mode 6) or nothing (mode 4) is added to the full 16-bit address modulo 2^16, and the operand is read there. `pc_out`=PC+2 and three reads are made.
- R8: In mode 7 the pointer P=(B+X) mod 256. The address low byte is read at P and the high byte at (P+1) mod 256, both in page zero, then the operand is read. `pc_out`=PC+1 and four reads are made.
- R9: In mode 8 the pointer P=B. The low byte L is read at P and the high byte H at (P+1) mod 256. `ea_out` low byte is (L+Y) mod 256 and the high byte is H plus the carry of L+Y, mod 256. `pc_out`=PC+1 and four reads are made.
- R10: `mem_req` stays high with `mem_addr` unchanged until a cycle with `mem_valid` high, and the sequencer advances only on that cycle, whatever the response latency.
- R11: `done` is high for exactly one cycle per accepted start, and all result outputs are valid in that cycle.
- R12: A `start` while `busy` is high is ignored, including in the `done` cycle; results are those of the accepted start and the unit is idle afterwards.
- R13: Synchronous reset `rst` returns the unit to idle with `mem_req`, `done` and `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin one address resolution when idle |
| grp_two | input | 1 | Field decode table select (0 first table, 1 second) |
| mode_field | input | 3 | Addressing-mode field |
| rel_sel | input | 1 | Branch offset fetch, overrides the field |
| pc_in | input | AW | Program counter at start |
| acc_in | input | DW | Accumulator value |
| x_in | input | DW | X index value |
| y_in | input | DW | Y index value |
| mem_addr | output | AW | Read address |
| mem_req | output | 1 | Read request |
| mem_valid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | DW | Read data |
| ea_out | output | AW | Effective address |
| operand | output | DW | Operand byte |
| pc_out | output | AW | Advanced program counter |
| mode_out | output | 4 | Resolved mode code |
| illegal | output | 1 | Field has no meaning in the selected table |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A sequence is in progress |

## Verification
The two functions that can meet in one cycle are the completion of a sequence and a new start request. The bench holds `start` high through the whole sequence of an indirect-indexed operation, including the `done` cycle, with a different group and field on the inputs. It judges the outcome by comparing the results with the first operation's arithmetically computed values and by requiring `busy` to be low in the cycle after `done`. Read latency is swept from zero to two wait cycles, so that the final data acceptance and the done pulse fall in varied positions.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;

   typedef enum logic [3:0] {
      EA_ACC = 4'd0,
      EA_IMM = 4'd1,
      EA_ZP  = 4'd2,
      EA_ZPX = 4'd3,
      EA_ABS = 4'd4,
      EA_ABX = 4'd5,
      EA_ABY = 4'd6,
      EA_IZX = 4'd7,
      EA_IZY = 4'd8,
      EA_REL = 4'd9,
      EA_BAD = 4'd15
   } ea_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPND,
      ST_HIGH,
      ST_PLO,
      ST_PHI,
      ST_DATA,
      ST_FIN
   } ea_state_e;

endpackage

// File: rtl/eaddr_mode_dec.sv
module eaddr_mode_dec
   import eaddr_pkg::*;
(
   input  logic       grp_two,
   input  logic [2:0] field,
   input  logic       rel,
   output ea_mode_e   mode,
   output logic       bad
);

   ea_mode_e first_tbl;
   ea_mode_e second_tbl;

   always_comb begin
      case (field)
         3'd0:    first_tbl = EA_IZX;
         3'd1:    first_tbl = EA_ZP;
         3'd2:    first_tbl = EA_IMM;
         3'd3:    first_tbl = EA_ABS;
         3'd4:    first_tbl = EA_IZY;
         3'd5:    first_tbl = EA_ZPX;
         3'd6:    first_tbl = EA_ABY;
         default: first_tbl = EA_ABX;
      endcase
   end

   always_comb begin
      case (field)
         3'd0:    second_tbl = EA_IMM;
         3'd1:    second_tbl = EA_ZP;
         3'd2:    second_tbl = EA_ACC;
         3'd3:    second_tbl = EA_ABS;
         3'd5:    second_tbl = EA_ZPX;
         3'd7:    second_tbl = EA_ABX;
         default: second_tbl = EA_BAD;
      endcase
   end

   always_comb begin
      if (rel)
         mode = EA_REL;
      else if (grp_two)
         mode = second_tbl;
      else
         mode = first_tbl;
      bad = (mode == EA_BAD);
   end

   always_comb begin
      if (rel) AST_REL_WINS: assert (mode == EA_REL) else $error("relative select lost"); // R3
      if (!rel && !grp_two) AST_FIRST_LEGAL: assert (!bad) else $error("first table gave illegal"); // R1
   end

endmodule

// File: rtl/eaddr_index_add.sv
module eaddr_index_add #(
   parameter int DW = 8,
   parameter int AW = 16
) (
   input  logic [DW-1:0] base_lo,
   input  logic [DW-1:0] base_hi,
   input  logic [DW-1:0] idx,
   input  logic [AW-1:0] pc_next,
   input  logic [DW-1:0] rel_off,
   output logic [DW-1:0] zp_sum,
   output logic [AW-1:0] wide_sum,
   output logic [AW-1:0] rel_tgt
);

   localparam int EXT = AW - DW;

   logic [DW:0] lo_sum;
   logic [DW-1:0] hi_sum;

   // page-zero sum drops the carry; the wide sum ripples it into the high byte
   assign lo_sum   = {1'b0, base_lo} + {1'b0, idx};
   assign zp_sum   = lo_sum[DW-1:0];
   assign hi_sum   = base_hi + {{(DW-1){1'b0}}, lo_sum[DW]};
   assign wide_sum = {hi_sum, lo_sum[DW-1:0]};
   assign rel_tgt  = pc_next + {{EXT{rel_off[DW-1]}}, rel_off};

   always_comb begin
      AST_WIDE_CARRY: assert (wide_sum == ({base_hi, base_lo} + {{EXT{1'b0}}, idx}))
         else $error("carry into high byte wrong"); // R9
   end

endmodule

// File: rtl/eaddr_rd_port.sv
module eaddr_rd_port #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_in,
   input  logic [AW-1:0] addr_in,
   input  logic          mem_valid,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   output logic          accept
);

   assign mem_req  = req_in;
   assign mem_addr = req_in ? addr_in : '0;
   assign accept   = req_in & mem_valid;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)))
      else $error("request dropped or address moved before data"); // R10

endmodule

// File: rtl/eaddr_seq.sv
module eaddr_seq
   import eaddr_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          grp_two,
   input  logic [2:0]    mode_field,
   input  logic          rel_sel,
   input  logic [AW-1:0] pc_in,
   input  logic [DW-1:0] acc_in,
   input  logic [DW-1:0] x_in,
   input  logic [DW-1:0] y_in,
   output logic [AW-1:0] mem_addr,
   output logic          mem_req,
   input  logic          mem_valid,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] ea_out,
   output logic [DW-1:0] operand,
   output logic [AW-1:0] pc_out,
   output logic [3:0]    mode_out,
   output logic          illegal,
   output logic          done,
   output logic          busy
);

   localparam int PAGE_HI = AW - DW;

   generate
      if (DW < 2) begin : g_bad_dw
         $error("data width too small");
      end
      if (AW != 2 * DW) begin : g_bad_aw
         $error("address width must be two data bytes");
      end
   endgenerate

   ea_state_e     state;
   ea_mode_e      mode_r;
   ea_mode_e      dec_mode;
   logic          dec_bad;
   logic [AW-1:0] pc_r;
   logic [AW-1:0] ea_r;
   logic [DW-1:0] opnd_r;
   logic [DW-1:0] lo_r;
   logic [DW-1:0] ptr_r;
   logic [DW-1:0] x_r;
   logic [DW-1:0] y_r;
   logic [DW-1:0] ptr_next;
   logic [AW-1:0] pc_next;
   logic          req_int;
   logic [AW-1:0] addr_int;
   logic          accept;
   logic [DW-1:0] add_lo;
   logic [DW-1:0] add_hi;
   logic [DW-1:0] add_idx;
   logic [DW-1:0] zp_sum;
   logic [AW-1:0] wide_sum;
   logic [AW-1:0] rel_tgt;
   logic          no_mem;

   eaddr_mode_dec u_dec (
      .grp_two (grp_two),
      .field   (mode_field),
      .rel     (rel_sel),
      .mode    (dec_mode),
      .bad     (dec_bad)
   );

   assign no_mem   = (dec_mode == EA_ACC) || dec_bad;
   assign ptr_next = ptr_r + {{(DW-1){1'b0}}, 1'b1};
   assign pc_next  = pc_r + {{(AW-1){1'b0}}, 1'b1};

   // operand sources for the shared adder, per state
   always_comb begin
      add_lo  = mem_rdata;
      add_hi  = '0;
      add_idx = '0;
      case (state)
         ST_OPND: begin
            add_lo = mem_rdata;
            if (mode_r == EA_ZPX || mode_r == EA_IZX) add_idx = x_r;
         end
         ST_HIGH: begin
            add_lo = lo_r;
            add_hi = mem_rdata;
            if (mode_r == EA_ABX) add_idx = x_r;
            else if (mode_r == EA_ABY) add_idx = y_r;
         end
         ST_PHI: begin
            add_lo = lo_r;
            add_hi = mem_rdata;
            if (mode_r == EA_IZY) add_idx = y_r;
         end
         default: ;
      endcase
   end

   eaddr_index_add #(.DW(DW), .AW(AW)) u_add (
      .base_lo  (add_lo),
      .base_hi  (add_hi),
      .idx      (add_idx),
      .pc_next  (pc_next),
      .rel_off  (mem_rdata),
      .zp_sum   (zp_sum),
      .wide_sum (wide_sum),
      .rel_tgt  (rel_tgt)
   );

   // read address per state
   always_comb begin
      req_int  = 1'b0;
      addr_int = '0;
      case (state)
         ST_OPND, ST_HIGH: begin
            req_int  = 1'b1;
            addr_int = pc_r;
         end
         ST_PLO: begin
            req_int  = 1'b1;
            addr_int = {{PAGE_HI{1'b0}}, ptr_r};
         end
         ST_PHI: begin
            req_int  = 1'b1;
            addr_int = {{PAGE_HI{1'b0}}, ptr_next};
         end
         ST_DATA: begin
            req_int  = 1'b1;
            addr_int = ea_r;
         end
         default: ;
      endcase
   end

   eaddr_rd_port #(.AW(AW)) u_port (
      .clk       (clk),
      .rst       (rst),
      .req_in    (req_int),
      .addr_in   (addr_int),
      .mem_valid (mem_valid),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .accept    (accept)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         mode_r <= EA_ACC;
         pc_r   <= '0;
         ea_r   <= '0;
         opnd_r <= '0;
         lo_r   <= '0;
         ptr_r  <= '0;
         x_r    <= '0;
         y_r    <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  mode_r <= dec_mode;
                  pc_r   <= pc_in;
                  x_r    <= x_in;
                  y_r    <= y_in;
                  ea_r   <= '0;
                  opnd_r <= (dec_mode == EA_ACC) ? acc_in : '0;
                  state  <= no_mem ? ST_FIN : ST_OPND;
               end
            end
            ST_OPND: begin
               if (accept) begin
                  pc_r <= pc_next;
                  case (mode_r)
                     EA_IMM: begin
                        opnd_r <= mem_rdata;
                        ea_r   <= pc_r;
                        state  <= ST_FIN;
                     end
                     EA_REL: begin
                        opnd_r <= mem_rdata;
                        ea_r   <= rel_tgt;
                        state  <= ST_FIN;
                     end
                     EA_ZP, EA_ZPX: begin
                        ea_r  <= {{PAGE_HI{1'b0}}, zp_sum};
                        state <= ST_DATA;
                     end
                     EA_IZX, EA_IZY: begin
                        ptr_r <= zp_sum;
                        state <= ST_PLO;
                     end
                     default: begin
                        lo_r  <= mem_rdata;
                        state <= ST_HIGH;
                     end
                  endcase
               end
            end
            ST_HIGH: begin
               if (accept) begin
                  pc_r  <= pc_next;
                  ea_r  <= wide_sum;
                  state <= ST_DATA;
               end
            end
            ST_PLO: begin
               if (accept) begin
                  lo_r  <= mem_rdata;
                  state <= ST_PHI;
               end
            end
            ST_PHI: begin
               if (accept) begin
                  ea_r  <= wide_sum;
                  state <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (accept) begin
                  opnd_r <= mem_rdata;
                  state  <= ST_FIN;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign ea_out   = ea_r;
   assign operand  = opnd_r;
   assign pc_out   = pc_r;
   assign mode_out = mode_r;
   assign illegal  = (mode_r == EA_BAD);
   assign done     = (state == ST_FIN);
   assign busy     = (state != ST_IDLE);

   logic rst_q;
   always_ff @(posedge clk) rst_q <= rst;

   always @(negedge clk) begin
      if (rst_q) AST_RST_IDLE: assert (!mem_req && !done && !busy)
         else $error("not idle after reset"); // R13
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done) else $error("done longer than one cycle"); // R11

   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
      (busy && start) |=> $stable(mode_out)) else $error("start accepted while busy"); // R12

   AST_ZP_PAGE: assert property (@(posedge clk) disable iff (rst)
      (done && (mode_out == EA_ZP || mode_out == EA_ZPX)) |-> (ea_out[AW-1:DW] == '0))
      else $error("zero-page address left page zero"); // R6

   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
      (!busy || done) |-> !mem_req) else $error("request while idle"); // R10

   AST_NOMEM_PC: assert property (@(posedge clk) disable iff (rst)
      (!busy && start && no_mem) |=> (!mem_req && done && pc_out == $past(pc_in)))
      else $error("memory-free mode touched memory or pc"); // R4

endmodule

// File: tb/eaddr_seq_tb_top.sv
module eaddr_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        grp_two = 1'b0;
   logic [2:0]  mode_field = '0;
   logic        rel_sel = 1'b0;
   logic [15:0] pc_in = '0;
   logic [7:0]  acc_in = '0;
   logic [7:0]  x_in = '0;
   logic [7:0]  y_in = '0;
   logic [15:0] mem_addr;
   logic        mem_req;
   logic        mem_valid = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic [15:0] ea_out;
   logic [7:0]  operand;
   logic [15:0] pc_out;
   logic [3:0]  mode_out;
   logic        illegal;
   logic        done;
   logic        busy;

   int n_chk = 0;
   int n_fail = 0;
   int lat_cfg = 0;
   int wcnt = 0;
   int rd_total = 0;
   int hold_err = 0;
   int cycles = 0;
   logic        prev_wait = 1'b0;
   logic [15:0] prev_addr = '0;

   always #10 clk = ~clk;

   eaddr_seq dut_i (
      .clk(clk), .rst(rst), .start(start), .grp_two(grp_two),
      .mode_field(mode_field), .rel_sel(rel_sel), .pc_in(pc_in),
      .acc_in(acc_in), .x_in(x_in), .y_in(y_in),
      .mem_addr(mem_addr), .mem_req(mem_req), .mem_valid(mem_valid),
      .mem_rdata(mem_rdata), .ea_out(ea_out), .operand(operand),
      .pc_out(pc_out), .mode_out(mode_out), .illegal(illegal),
      .done(done), .busy(busy)
   );

   function automatic logic [7:0] memf(input logic [15:0] a);
      return (a[7:0] * 8'd7) ^ (a[15:8] * 8'd13) ^ 8'h3C;
   endfunction

   // memory with programmable wait cycles
   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (rst) begin
         mem_valid <= 1'b0;
         wcnt      <= 0;
      end else if (mem_req && !mem_valid) begin
         if (wcnt >= lat_cfg) begin
            mem_valid <= 1'b1;
            mem_rdata <= memf(mem_addr);
            wcnt      <= 0;
         end else begin
            wcnt <= wcnt + 1;
         end
      end else begin
         mem_valid <= 1'b0;
         wcnt      <= 0;
      end
      if (mem_req && mem_valid) rd_total <= rd_total + 1;
      prev_wait <= mem_req && !mem_valid && !rst;
      prev_addr <= mem_addr;
      if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_err <= hold_err + 1;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(input int m);
      case (m)
         0: return "R4";
         1: return "R5";
         2, 3: return "R6";
         4, 5, 6: return "R7";
         7: return "R8";
         8: return "R9";
         9: return "R3";
         default: return "R2";
      endcase
   endfunction

   task automatic model(input bit g, input bit [2:0] f, input bit r, input int pc,
                        input int a, input int x, input int y,
                        output int m, output int ea, output int op, output int npc,
                        output int ill, output int nrd);
      int b, lo, hi, p;
      ill = 0; ea = 0; op = 0; npc = pc; nrd = 0;
      if (r) m = 9;
      else if (!g) begin
         case (f)
            0: m = 7; 1: m = 2; 2: m = 1; 3: m = 4;
            4: m = 8; 5: m = 3; 6: m = 6; default: m = 5;
         endcase
      end else begin
         case (f)
            0: m = 1; 1: m = 2; 2: m = 0; 3: m = 4;
            5: m = 3; 7: m = 5; default: m = 15;
         endcase
      end
      b = memf(16'(pc));
      case (m)
         0: op = a;
         15: ill = 1;
         1: begin op = b; ea = pc; npc = (pc + 1) & 16'hFFFF; nrd = 1; end
         9: begin
            op = b; npc = (pc + 1) & 16'hFFFF; nrd = 1;
            ea = (npc + ((b >= 128) ? b - 256 : b)) & 16'hFFFF;
         end
         2, 3: begin
            ea = (m == 3) ? (b + x) & 8'hFF : b;
            op = memf(16'(ea)); npc = (pc + 1) & 16'hFFFF; nrd = 2;
         end
         4, 5, 6: begin
            hi = memf(16'((pc + 1) & 16'hFFFF));
            ea = hi * 256 + b;
            if (m == 5) ea = ea + x;
            if (m == 6) ea = ea + y;
            ea = ea & 16'hFFFF;
            op = memf(16'(ea)); npc = (pc + 2) & 16'hFFFF; nrd = 3;
         end
         default: begin
            p  = (m == 7) ? (b + x) & 8'hFF : b;
            lo = memf(16'(p));
            hi = memf(16'((p + 1) & 8'hFF));
            ea = hi * 256 + lo;
            if (m == 8) ea = (ea + y) & 16'hFFFF;
            op = memf(16'(ea)); npc = (pc + 1) & 16'hFFFF; nrd = 4;
         end
      endcase
   endtask

   task automatic run_op(input bit g, input bit [2:0] f, input bit r, input int pc,
                         input int a, input int x, input int y, input int lat);
      int m, ea, op, npc, ill, nrd, rd0, w;
      string t;
      model(g, f, r, pc, a, x, y, m, ea, op, npc, ill, nrd);
      t = tag_of(m);
      @(negedge clk);
      grp_two = g; mode_field = f; rel_sel = r; pc_in = 16'(pc);
      acc_in = 8'(a); x_in = 8'(x); y_in = 8'(y); lat_cfg = lat;
      rd0 = rd_total;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      w = 0;
      while (!done && w < 100) begin
         @(negedge clk);
         w++;
      end
      chk("R11", "done seen", int'(done), 1);
      chk((m == 15) ? "R2" : (g ? "R2" : (r ? "R3" : "R1")), "mode", int'(mode_out), m);
      chk(t, "illegal", int'(illegal), ill);
      chk(t, "ea", int'(ea_out), ea);
      chk(t, "operand", int'(operand), op);
      chk(t, "pc", int'(pc_out), npc);
      chk(t, "reads", rd_total - rd0, nrd);
      @(negedge clk);
      chk("R11", "done drop", int'(done), 0);
   endtask

   initial begin
      int pcs[4];
      int xs[4];
      int ys[4];
      int fpc, m, ea, op, npc, ill, nrd, w;
      pcs = '{16'h0400, 16'h12F0, 16'hFFFE, 16'h80C3};
      xs  = '{8'h00, 8'hFF, 8'h35, 8'h80};
      ys  = '{8'h01, 8'h7F, 8'hFF, 8'hC4};

      repeat (3) @(negedge clk);
      chk("R13", "req in reset", int'(mem_req), 0);
      chk("R13", "busy in reset", int'(busy), 0);
      chk("R13", "done in reset", int'(done), 0);
      rst = 1'b0;

      // sweep of both tables, all fields, several register sets and latencies
      for (int g = 0; g < 2; g++)
         for (int f = 0; f < 8; f++)
            for (int k = 0; k < 4; k++)
               run_op(g[0], 3'(f), 1'b0, pcs[k], 8'h5A + k, xs[k], ys[k], (f + k) % 3);

      // relative: forward and backward offsets, page crossing
      for (int k = 0; k < 4; k++)
         run_op(1'b0, 3'(k), 1'b1, pcs[k], 0, 0, 0, k % 3);

      // R8: pointer 0xFF fetches its high byte from 0x00
      fpc = 16'h0500;
      run_op(1'b0, 3'd0, 1'b0, fpc, 0, (8'hFF - memf(16'(fpc))) & 8'hFF, 0, 1);

      // R9: pointer 0xFF and carry into the high byte
      fpc = 16'h0300;
      for (int s = 0; s < 256; s++)
         if (memf(16'(16'h0300 + s)) == 8'hFF && fpc == 16'h0300) fpc = 16'h0300 + s;
      run_op(1'b0, 3'd4, 1'b0, fpc, 0, 0, 8'hFF, 2);
      run_op(1'b0, 3'd4, 1'b0, fpc, 0, 0, 8'h01, 0);

      // R12: start held high through an operation and its done cycle
      model(1'b0, 3'd4, 1'b0, 16'h2222, 0, 0, 8'h90, m, ea, op, npc, ill, nrd);
      @(negedge clk);
      grp_two = 1'b0; mode_field = 3'd4; rel_sel = 1'b0; pc_in = 16'h2222;
      y_in = 8'h90; lat_cfg = 1;
      start = 1'b1;
      @(negedge clk);
      grp_two = 1'b1; mode_field = 3'd2; pc_in = 16'h7777; y_in = 8'h00;
      w = 0;
      while (!done && w < 100) begin
         @(negedge clk);
         w++;
      end
      chk("R12", "done while start held", int'(done), 1);
      chk("R12", "mode kept", int'(mode_out), 8);
      chk("R12", "ea kept", int'(ea_out), ea);
      chk("R12", "operand kept", int'(operand), op);
      chk("R12", "pc kept", int'(pc_out), npc);
      @(negedge clk);
      start = 1'b0;
      chk("R12", "idle after done", int'(busy), 0);
      chk("R12", "no request after done", int'(mem_req), 0);

      // R13: reset in the middle of an absolute fetch
      @(negedge clk);
      grp_two = 1'b0; mode_field = 3'd3; pc_in = 16'h4000; lat_cfg = 2;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      chk("R13", "busy before reset", int'(busy), 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R13", "req after reset", int'(mem_req), 0);
      chk("R13", "busy after reset", int'(busy), 0);
      chk("R13", "done after reset", int'(done), 0);
      run_op(1'b1, 3'd0, 1'b0, 16'h0A0A, 0, 0, 0, 0);

      chk("R10", "request held until data", hold_err, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule